// File: doc/BRIEF.md
# Stereo Transmit Sample Queue with Fault Reporting

This block sits between a processor and a serial audio transmitter. It keeps two independent queues of 32-bit samples, one per channel. Software fills them through a single write port: a select bit picks the left or the right queue. The transmitter takes one left/right pair per request. Software can write a run of left samples and then the same number of right samples. It can also alternate left, right, left, right. In either case the left sample of a pair is written before its right partner.

The block reports three conditions. The first is a combined empty flag, which tells software that more data is needed before the transmitter starves. The second is a sticky error flag for a real starvation or a dropped write. The third is a sticky flag showing that the hardware has realigned the two channels. Realignment happens when a pop finds the two queues more than one entry apart: both queues are flushed, so that later pairs start from a clean left/right alignment.

A small pop controller is built as a state machine that remembers the outcome of the most recent pop. Its states are:
- `PS_IDLE`: no pop has happened since reset.
- `PS_SENT`: a pair was delivered.
- `PS_STARVED`: a pop found a queue empty.
- `PS_REALIGN`: a pop triggered a flush.

On every `pop_req` the machine moves to one of `PS_SENT`, `PS_STARVED` or `PS_REALIGN`. It checks the realign condition first, then starvation, and otherwise delivers. Without a request it stays where it is. The sample outputs show the captured pair only in `PS_SENT`. In the other three states they show zeros.

Top module: `stereo_tx_fifo`

## Requirements
- R1: After reset both queues hold zero entries, `fifo_empty` is 1, `err_xrun` and `err_resync` are 0, and `pop_left`/`pop_right` are 0.
- R2: A write with `wr_sel`=0 appends the whole 32-bit `wr_data` word to the left queue, and `wr_sel`=1 appends it to the right queue. A pop with both queues non-empty removes the oldest entry of each. From the clock edge that samples `pop_req`, `pop_left`/`pop_right` show those entries.
- R3: `fifo_empty` is 1 exactly when both queues hold zero entries, as seen after each clock edge.
- R4: Each queue holds 8 entries. A write to a queue that held 8 entries at the start of the cycle is dropped, leaves the stored words unchanged and sets `err_xrun`. This holds even if the same cycle pops that queue.
- R5: A pop when the two occupancies differ by at most one, but at least one queue is empty, removes nothing. It drives both sample outputs to 0 and sets `err_xrun`.
- R6: A pop when the occupancies differ by more than one flushes both queues. It drives both sample outputs to 0 and sets `err_resync`. No `err_xrun` is caused by this pop.
- R7: `err_xrun` and `err_resync` stay at 1 until a cycle with `clr_flags`=1 clears them. If a setting event happens in the same cycle as a clear, the flag ends up at 1.
- R8: Both write orders give correct pairs: a block of N left words followed by N right words, and alternating left/right words. N is at most 8, and no pop happens inside a block.
- R9: A write in the same cycle as a realigning flush is discarded and does not set `err_xrun`.
- R10: Without `pop_req`, `pop_left`/`pop_right` keep their value. Writes and flag clears do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the processor |
| wr_sel | input | 1 | Channel address: 0 left, 1 right |
| wr_data | input | 32 | Sample word to store |
| pop_req | input | 1 | Transmitter request for one left/right pair |
| clr_flags | input | 1 | Clears the sticky error and realign flags |
| pop_left | output | 32 | Left sample of the last pop (0 on starvation or realign) |
| pop_right | output | 32 | Right sample of the last pop (0 on starvation or realign) |
| fifo_empty | output | 1 | Both queues are empty |
| err_xrun | output | 1 | Sticky: starvation or dropped write |
| err_resync | output | 1 | Sticky: queues were realigned by a flush |

## Verification
The main function is tried with several input patterns, each of which separates a different fault:
- Alternating left/right writes with pops in between separate correct pairing from a swapped channel or a wrong read order.
- Block writes (a run of left words, then right words) show that the occupancy gap alone decides realignment, not the write order.
- Single-sided writes followed by a pop separate starvation (gap of one, nothing removed) from realignment (gap above one, everything flushed).
- Filling a queue and writing once more separates a dropped write from an overwrite, because the eight pops that follow must return the original words.
- A seeded random mix of writes, pops and clears, checked against a queue model in the bench, covers the same-cycle cases: a write and a pop together, a clear and an event together, and a write together with a flush.

// File: rtl/stfifo_pkg.sv
package stfifo_pkg;

    // Outcome of the most recent pop request
    typedef enum logic [1:0] {
        PS_IDLE    = 2'd0,
        PS_SENT    = 2'd1,
        PS_STARVED = 2'd2,
        PS_REALIGN = 2'd3
    } pop_state_t;

    // Channel indices
    localparam int CH_LEFT  = 0;
    localparam int CH_RIGHT = 1;
    localparam int NUM_CH   = 2;

    // Sticky flag indices
    localparam int FLG_XRUN   = 0;
    localparam int FLG_RESYNC = 1;
    localparam int NUM_FLG    = 2;

endpackage

// File: rtl/chan_fifo.sv
module chan_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    input  logic             flush,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP      = CNT_W'(DEPTH);

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == CAP);
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = store[rptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/pop_ctrl.sv
module pop_ctrl
    import stfifo_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_req,
    input  logic [CNT_W-1:0] occ_l,
    input  logic [CNT_W-1:0] occ_r,
    input  logic [W-1:0]     head_l,
    input  logic [W-1:0]     head_r,
    output logic             take,
    output logic             flush,
    output logic             starve_evt,
    output logic             realign_evt,
    output logic [W-1:0]     out_l,
    output logic [W-1:0]     out_r
);

    pop_state_t       state;
    pop_state_t       nxt;
    logic [CNT_W-1:0] gap;
    logic             gap_wide;
    logic             side_dry;
    logic [W-1:0]     cap_l;
    logic [W-1:0]     cap_r;

    assign gap      = (occ_l > occ_r) ? (occ_l - occ_r) : (occ_r - occ_l);
    assign gap_wide = (gap > CNT_W'(1));
    assign side_dry = (occ_l == '0) || (occ_r == '0);

    // Next-state decision: realign outranks starvation, starvation outranks delivery
    always_comb begin
        nxt = state;
        unique case (state)
            PS_IDLE, PS_SENT, PS_STARVED, PS_REALIGN: begin
                if (pop_req) begin
                    if (gap_wide) begin
                        nxt = PS_REALIGN;
                    end else if (side_dry) begin
                        nxt = PS_STARVED;
                    end else begin
                        nxt = PS_SENT;
                    end
                end
            end
            default: nxt = PS_IDLE;
        endcase
    end

    assign take        = pop_req && (nxt == PS_SENT);
    assign flush       = pop_req && (nxt == PS_REALIGN);
    assign starve_evt  = pop_req && (nxt == PS_STARVED);
    assign realign_evt = flush;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Captured pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_l <= '0;
            cap_r <= '0;
        end else if (take) begin
            cap_l <= head_l;
            cap_r <= head_r;
        end
    end

    // Outputs by state
    always_comb begin
        unique case (state)
            PS_SENT: begin
                out_l = cap_l;
                out_r = cap_r;
            end
            PS_IDLE, PS_STARVED, PS_REALIGN: begin
                out_l = '0;
                out_r = '0;
            end
            default: begin
                out_l = '0;
                out_r = '0;
            end
        endcase
    end

endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else if (set[i]) begin
                q[i] <= 1'b1;
            end else if (clr) begin
                q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/stereo_tx_fifo.sv
module stereo_tx_fifo
    import stfifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop_req,
    input  logic              clr_flags,
    output logic [DATA_W-1:0] pop_left,
    output logic [DATA_W-1:0] pop_right,
    output logic              fifo_empty,
    output logic              err_xrun,
    output logic              err_resync
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  occ   [NUM_CH];
    logic [DATA_W-1:0] head  [NUM_CH];
    logic              full  [NUM_CH];
    logic              empty [NUM_CH];
    logic              push  [NUM_CH];
    logic              take;
    logic              flush;
    logic              starve_evt;
    logic              realign_evt;
    logic              over_evt;
    logic [NUM_FLG-1:0] flag_set;
    logic [NUM_FLG-1:0] flag_q;

    pop_ctrl #(.W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop_req    (pop_req),
        .occ_l      (occ[CH_LEFT]),
        .occ_r      (occ[CH_RIGHT]),
        .head_l     (head[CH_LEFT]),
        .head_r     (head[CH_RIGHT]),
        .take       (take),
        .flush      (flush),
        .starve_evt (starve_evt),
        .realign_evt(realign_evt),
        .out_l      (pop_left),
        .out_r      (pop_right)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        assign push[ch] = wr_en && (wr_sel == (ch == CH_RIGHT)) && !flush && !full[ch];

        chan_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push[ch]),
            .push_data(wr_data),
            .pop      (take),
            .flush    (flush),
            .head     (head[ch]),
            .count    (occ[ch]),
            .full     (full[ch]),
            .empty    (empty[ch])
        );
    end

    assign over_evt = wr_en && !flush && (wr_sel ? full[CH_RIGHT] : full[CH_LEFT]);

    assign flag_set[FLG_XRUN]   = over_evt || starve_evt;
    assign flag_set[FLG_RESYNC] = realign_evt;

    sticky_flags #(.N(NUM_FLG)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (flag_set),
        .clr  (clr_flags),
        .q    (flag_q)
    );

    assign fifo_empty = empty[CH_LEFT] && empty[CH_RIGHT];
    assign err_xrun   = flag_q[FLG_XRUN];
    assign err_resync = flag_q[FLG_RESYNC];

endmodule

// File: rtl/stfifo_checker.sv
module stfifo_checker #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_sel,
    input logic              pop_req,
    input logic              clr_flags,
    input logic [DATA_W-1:0] pop_left,
    input logic [DATA_W-1:0] pop_right,
    input logic              fifo_empty,
    input logic              err_xrun,
    input logic              err_resync,
    input logic [CNT_W-1:0]  occ_l,
    input logic [CNT_W-1:0]  occ_r
);

    logic wide;
    logic dry;
    assign wide = (occ_l > occ_r) ? (occ_l - occ_r > CNT_W'(1)) : (occ_r - occ_l > CNT_W'(1));
    assign dry  = (occ_l == '0) || (occ_r == '0);

    // R4
    bound_occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_l <= CNT_W'(DEPTH)) && (occ_r <= CNT_W'(DEPTH)));

    // R4
    drop_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && occ_l == CNT_W'(DEPTH) && !(pop_req && wide)) |=> err_xrun);

    // R5
    starve_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !wide && dry) |=> (err_xrun && pop_left == '0 && pop_right == '0));

    // R6
    realign_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && wide) |=> (fifo_empty && err_resync && pop_left == '0 && pop_right == '0));

    // R7
    xrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_xrun && !clr_flags) |=> err_xrun);

    // R7
    resync_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_resync && !clr_flags) |=> err_resync);

    // R10
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_req |=> ($stable(pop_left) && $stable(pop_right)));

endmodule

bind stereo_tx_fifo stfifo_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .pop_req   (pop_req),
    .clr_flags (clr_flags),
    .pop_left  (pop_left),
    .pop_right (pop_right),
    .fifo_empty(fifo_empty),
    .err_xrun  (err_xrun),
    .err_resync(err_resync),
    .occ_l     (occ[0]),
    .occ_r     (occ[1])
);

// File: tb/stereo_tx_fifo_test.sv
module stereo_tx_fifo_test;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        pop_req = 1'b0;
    logic        clr_flags = 1'b0;
    logic [31:0] pop_left;
    logic [31:0] pop_right;
    logic        fifo_empty;
    logic        err_xrun;
    logic        err_resync;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // Bench model
    logic [31:0] ql[$];
    logic [31:0] qr[$];
    logic [31:0] m_l = '0;
    logic [31:0] m_r = '0;
    bit m_x = 0;
    bit m_s = 0;

    always #4 clk = ~clk;

    stereo_tx_fifo uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pop_req(pop_req), .clr_flags(clr_flags), .pop_left(pop_left), .pop_right(pop_right),
        .fifo_empty(fifo_empty), .err_xrun(err_xrun), .err_resync(err_resync)
    );

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int gap_of(int a, int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // Model one cycle from the requirements
    task automatic model(bit wr, bit sel, logic [31:0] d, bit pop, bit clr);
        int nl = ql.size();
        int nr = qr.size();
        bit realign = pop && (gap_of(nl, nr) > 1);
        bit starve  = pop && !realign && (nl == 0 || nr == 0);
        bit good    = pop && !realign && !starve;
        bit over    = 0;
        if (wr && !realign) begin
            if ((sel ? nr : nl) == DEPTH) over = 1;
        end
        if (realign) begin
            ql.delete();
            qr.delete();
            m_l = '0;
            m_r = '0;
        end else if (starve) begin
            m_l = '0;
            m_r = '0;
        end else if (good) begin
            m_l = ql.pop_front();
            m_r = qr.pop_front();
        end
        if (wr && !realign && !over) begin
            if (sel) qr.push_back(d);
            else ql.push_back(d);
        end
        if (over || starve) m_x = 1; else if (clr) m_x = 0;
        if (realign) m_s = 1; else if (clr) m_s = 0;
    endtask

    task automatic compare(string tag);
        bit e = (ql.size() == 0) && (qr.size() == 0);
        check(pop_left == m_l, tag, "pop_left", pop_left, m_l);
        check(pop_right == m_r, tag, "pop_right", pop_right, m_r);
        check(fifo_empty == e, tag, "fifo_empty", 32'(fifo_empty), 32'(e));
        check(err_xrun == m_x, tag, "err_xrun", 32'(err_xrun), 32'(m_x));
        check(err_resync == m_s, tag, "err_resync", 32'(err_resync), 32'(m_s));
    endtask

    // Called at a negedge: drive, advance one cycle, compare at next negedge
    task automatic step(bit wr, bit sel, logic [31:0] d, bit pop, bit clr, string tag);
        wr_en = wr; wr_sel = sel; wr_data = d; pop_req = pop; clr_flags = clr;
        model(wr, sel, d, pop, clr);
        @(negedge clk);
        wr_en = 0; pop_req = 0; clr_flags = 0;
        compare(tag);
    endtask

    task automatic wr_l(logic [31:0] d, string tag); step(1, 0, d, 0, 0, tag); endtask
    task automatic wr_r(logic [31:0] d, string tag); step(1, 1, d, 0, 0, tag); endtask
    task automatic pop1(string tag);                 step(0, 0, '0, 1, 0, tag); endtask
    task automatic idle(string tag);                 step(0, 0, '0, 0, 0, tag); endtask
    task automatic clr1(string tag);                 step(0, 0, '0, 0, 1, tag); endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        bit nsel;
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        compare("R1");
        idle("R1");

        // R2, R8: alternating pairs
        for (int i = 0; i < 3; i++) begin
            wr_l(32'hA000_0000 + i, "R8");
            wr_r(32'hB000_0000 + i, "R8");
        end
        for (int i = 0; i < 3; i++) pop1("R2");
        // R10: outputs hold without pop
        wr_l(32'h1234_5678, "R10");
        clr1("R10");
        idle("R10");
        wr_r(32'h8765_4321, "R10");
        pop1("R2");

        // R8: block write of left then right
        for (int i = 0; i < 4; i++) wr_l(32'hC100_0000 + i, "R8");
        for (int i = 0; i < 4; i++) wr_r(32'hD100_0000 + i, "R8");
        for (int i = 0; i < 4; i++) pop1("R8");
        // R3: empty again after draining
        idle("R3");

        // R4: fill, overflow left, drain in order
        for (int i = 0; i < DEPTH; i++) begin
            wr_l(32'hE000_0000 + i, "R4");
            wr_r(32'hF000_0000 + i, "R4");
        end
        wr_l(32'hDEAD_BEEF, "R4");
        step(1, 1, 32'hBAD0_0001, 1, 0, "R4"); // full right write with pop: still dropped
        for (int i = 0; i < DEPTH - 1; i++) pop1("R4");
        // R5: one-sided starvation and both-empty starvation
        pop1("R5");
        clr1("R7");
        wr_l(32'h5555_0001, "R5");
        pop1("R5");
        wr_r(32'h5555_0002, "R5");
        pop1("R5");

        // R7: clear concurrent with starve keeps flag set
        step(0, 0, '0, 1, 1, "R7");
        clr1("R7");

        // R6, R9: gap over one flushes; concurrent write discarded
        wr_l(32'h6666_0001, "R6");
        wr_l(32'h6666_0002, "R6");
        step(1, 1, 32'h9999_0009, 1, 0, "R9");
        idle("R6");
        step(0, 0, '0, 0, 1, "R7");

        // Random mix
        nsel = 0;
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(99);
            bit s = ($urandom_range(19) == 0) ? ~nsel : nsel;
            bit c = ($urandom_range(24) == 0);
            if (r < 55) begin
                step(1, s, $urandom(), ($urandom_range(9) == 0), c, "R2");
                nsel = ~s;
            end else if (r < 90) begin
                step(0, 0, '0, 1, c, "R5");
            end else begin
                step(0, 0, '0, 0, c, "R7");
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule